// File: doc/BRIEF.md
# Multiplexed Local Memory Cycle Controller

This block runs one local memory transaction at a time on a 32-bit bus that carries address and data on the same lines. It serves DRAM and VRAM. A requester hands over a word address, a 4-bit status code, the direction, the byte enables, the write data and a word count. The controller first puts the address and status on the bus and raises a latch strobe. It drops the strobe together with the row strobe while the row half of the address sits on the 13-bit row/column bus. It then switches to the column address and runs the data phase with per-byte column strobes. It also steers the transceiver direction enables.

The memory side answers in the data phase through four inputs. Ready holds the cycle, one clock per wait state. Bus fault, taken together with ready, restarts the cycle from the address phase. Bus fault without ready aborts the transaction with an error. The address decoder reports two things while the row strobe first falls: a page-mode flag, so later words of a burst stay on the open row, and a 16-bit port flag, so each word moves as two halves on the low lanes. Each finished word is returned to the requester one clock later as a response pulse.

Top module: `lmem_cycle_ctrl`

## Requirements
- R1: A request taken while idle (req_ack high for that clock) starts an address phase in the next clock. For one clock, lad_oe is high and lad_out = {word address, status}, with the address on bits 31..4 and the status on bits 3..0. ale is high and ras_n is high.
- R2: In the clock after the address phase, ale falls low and ras_n goes low. rca then carries the row, word address bits 24..12, and all cas_n are high.
- R3: In every data-phase and precharge clock, rca carries the column. Let h be the half select, which is 0 except for the second half of a 16-bit transfer. Form {address bits 11..0, h}. rca is this value when colmode is low and this value shifted right by one when colmode is high.
- R4: In a data-phase clock with rdy low and fault low, the cycle holds with unchanged strobes and address, so each such clock adds exactly one clock to the transfer.
- R5: In a data-phase clock with rdy high and fault high, the row strobe is released and the same transfer restarts with a full address phase in the next clock.
- R6: In a data-phase clock with fault high and rdy low, the transaction ends. The next clock carries rsp_valid with rsp_err=1 and rsp_last=1, the controller returns to idle, and the remaining words are dropped.
- R7: page_n and half_n are sampled in the clock in which ras_n first goes low. With page_n low, each further word of a burst follows one precharge clock (ras_n low, all cas_n high) at the next word address. With page_n high, each further word starts a new address phase.
- R8: With half_n low, each word moves as two transfers on lanes 15..0. The first moves bytes 1..0 and the second moves bytes 3..2. Only cas_n[1:0] are used. In a write, both 16-bit halves of lad_out carry the selected half. A read returns the two halves assembled in order, and the second transfer follows one precharge clock.
- R9: In a data-phase clock, cas_n[i] is low for every enabled byte i on a write and for every lane in use on a read. Outside the data phase, all cas_n are high.
- R10: ddin is high exactly in read data-phase clocks. ddout_n is low exactly in write data-phase clocks, and lad_oe is high in those clocks. The two enables are never active together.
- R11: One clock after a data phase completes a word (rdy high, fault low), rsp_valid pulses with rsp_err=0. For a read, rsp_data holds the read word. rsp_last is high on the final word of the request.
- R12: While not idle, requests are ignored and req_ack stays low. While idle, req_ack equals req_valid and all strobes are inactive (ale high, ras_n high, cas_n all high, lad_oe low, ddin low, ddout_n high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 28 | Word address |
| req_status | input | 4 | Cycle status code sent with the address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data, repeated for every word of a burst |
| req_len | input | 2 | Number of words minus one |
| req_ack | output | 1 | Request accepted this clock |
| rsp_valid | output | 1 | Word finished or transaction aborted |
| rsp_data | output | 32 | Read word |
| rsp_err | output | 1 | Aborted by bus fault |
| rsp_last | output | 1 | Final response of the request |
| lad_out | output | 32 | Bus value driven out |
| lad_in | input | 32 | Bus value read in |
| lad_oe | output | 1 | Bus output enable |
| ale | output | 1 | Address latch strobe, falling edge holds address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 4 | Column strobes per byte, active low |
| rca | output | 13 | Multiplexed row/column address |
| colmode | input | 1 | Column shift select for the addressed memory |
| rdy | input | 1 | Ready, low adds wait states |
| fault | input | 1 | Bus fault |
| page_n | input | 1 | Low: addressed memory allows page bursts |
| half_n | input | 1 | Low: addressed memory is 16 bits wide |
| ddin | output | 1 | Transceiver inbound enable, active high |
| ddout_n | output | 1 | Transceiver outbound enable, active low |

## Verification
Ready and bus fault are read in the same data-phase clock. Their four combinations decide between completion, wait, retry and abort, so the collision of a retry with a word that would otherwise have completed is the case of most interest. The bench provokes it with directed retries in a data phase of a 16-bit transfer and of a burst, and mixes random ready and fault levels everywhere. A reference model that tracks phases judges each case: it expects a fresh address phase with the same address and half select, and no response pulse in that clock.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_ROW  = 3'd2,
    ST_COL  = 3'd3,
    ST_PRE  = 3'd4
  } lmc_state_t;
endpackage

// File: rtl/lmc_rcmux.sv
module lmc_rcmux #(
  parameter int RCA_W = 13,
  localparam int ROW_LSB = RCA_W - 1,
  localparam int AIN_W = ROW_LSB + RCA_W
) (
  input  logic [AIN_W-1:0] addr,
  input  logic             hsel,
  input  logic             colmode,
  input  logic             col_phase,
  output logic [RCA_W-1:0] rca
);
  logic [RCA_W-1:0] row_val;
  logic [RCA_W-1:0] col_base;
  logic [RCA_W-1:0] col_val;

  assign row_val  = addr[ROW_LSB +: RCA_W];
  assign col_base = {addr[ROW_LSB-1:0], hsel};
  // column shift lets narrower column matrices share the bus
  assign col_val  = colmode ? (col_base >> 1) : col_base;
  assign rca      = col_phase ? col_val : row_val;
endmodule

// File: rtl/lmc_lanes.sv
module lmc_lanes #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int HALF  = LANES / 2,
  localparam int HW    = DATA_W / 2
) (
  input  logic              wr,
  input  logic [LANES-1:0]  be,
  input  logic              half,
  input  logic              hsel,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  cas_act,
  output logic [DATA_W-1:0] lane_data
);
  logic [HW-1:0] sel_half;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i < HALF) begin : g_low
      assign cas_act[i] = half ? (wr ? (hsel ? be[i+HALF] : be[i]) : 1'b1)
                               : (wr ? be[i] : 1'b1);
    end else begin : g_high
      assign cas_act[i] = !half && (wr ? be[i] : 1'b1);
    end
  end

  assign sel_half  = hsel ? wdata[DATA_W-1:HW] : wdata[HW-1:0];
  assign lane_data = half ? {sel_half, sel_half} : wdata;
endmodule

// File: rtl/lmc_seq.sv
module lmc_seq
  import lmc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int STAT_W  = 4,
  parameter int LEN_W   = 2,
  localparam int LANES   = DATA_W / 8,
  localparam int HW      = DATA_W / 2,
  localparam int WADDR_W = DATA_W - STAT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [WADDR_W-1:0] req_addr,
  input  logic [STAT_W-1:0]  req_status,
  input  logic               req_write,
  input  logic [LANES-1:0]   req_be,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [LEN_W-1:0]   req_len,
  output logic               req_ack,
  input  logic               rdy,
  input  logic               fault,
  input  logic               page_n,
  input  logic               half_n,
  input  logic [DATA_W-1:0]  lad_in,
  output lmc_state_t         st,
  output logic [WADDR_W-1:0] cur_addr,
  output logic [STAT_W-1:0]  cur_stat,
  output logic               cur_wr,
  output logic [LANES-1:0]   cur_be,
  output logic [DATA_W-1:0]  cur_wdata,
  output logic               hsel,
  output logic               half_q,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_err,
  output logic               rsp_last
);
  lmc_state_t         st_n;
  logic [WADDR_W-1:0] addr_n;
  logic [STAT_W-1:0]  stat_n;
  logic               wr_n;
  logic [LANES-1:0]   be_n;
  logic [DATA_W-1:0]  wd_n;
  logic [LEN_W-1:0]   left, left_n;
  logic               hsel_n, half_n_q, page_q, page_n_q;
  logic [DATA_W-1:0]  rdata_n;
  logic               rv_n, re_n, rl_n;

  assign req_ack = (st == ST_IDLE) && req_valid;

  always_comb begin
    st_n     = st;
    addr_n   = cur_addr;
    stat_n   = cur_stat;
    wr_n     = cur_wr;
    be_n     = cur_be;
    wd_n     = cur_wdata;
    left_n   = left;
    hsel_n   = hsel;
    half_n_q = half_q;
    page_n_q = page_q;
    rdata_n  = rsp_data;
    rv_n     = 1'b0;
    re_n     = 1'b0;
    rl_n     = 1'b0;
    case (st)
      ST_IDLE: if (req_valid) begin
        addr_n = req_addr;
        stat_n = req_status;
        wr_n   = req_write;
        be_n   = req_be;
        wd_n   = req_wdata;
        left_n = req_len;
        hsel_n = 1'b0;
        st_n   = ST_ADDR;
      end
      ST_ADDR: st_n = ST_ROW;
      ST_ROW: begin
        half_n_q = !half_n;
        page_n_q = !page_n;
        st_n     = ST_COL;
      end
      ST_COL: begin
        if (fault) begin
          if (rdy) begin
            st_n = ST_ADDR;            // externally requested retry
          end else begin
            st_n   = ST_IDLE;          // abort with error
            hsel_n = 1'b0;
            rv_n   = 1'b1;
            re_n   = 1'b1;
            rl_n   = 1'b1;
          end
        end else if (rdy) begin
          if (half_q && !hsel) begin
            hsel_n            = 1'b1;
            rdata_n[HW-1:0]   = lad_in[HW-1:0];
            st_n              = ST_PRE;
          end else begin
            if (half_q) rdata_n[DATA_W-1:HW] = lad_in[HW-1:0];
            else        rdata_n = lad_in;
            rv_n   = 1'b1;
            hsel_n = 1'b0;
            if (left == '0) begin
              rl_n = 1'b1;
              st_n = ST_IDLE;
            end else begin
              left_n = left - 1'b1;
              addr_n = cur_addr + 1'b1;
              st_n   = page_q ? ST_PRE : ST_ADDR;
            end
          end
        end
      end
      ST_PRE: st_n = ST_COL;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_addr  <= '0;
      cur_stat  <= '0;
      cur_wr    <= 1'b0;
      cur_be    <= '0;
      cur_wdata <= '0;
      left      <= '0;
      hsel      <= 1'b0;
      half_q    <= 1'b0;
      page_q    <= 1'b0;
      rsp_data  <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_last  <= 1'b0;
    end else begin
      st        <= st_n;
      cur_addr  <= addr_n;
      cur_stat  <= stat_n;
      cur_wr    <= wr_n;
      cur_be    <= be_n;
      cur_wdata <= wd_n;
      left      <= left_n;
      hsel      <= hsel_n;
      half_q    <= half_n_q;
      page_q    <= page_n_q;
      rsp_data  <= rdata_n;
      rsp_valid <= rv_n;
      rsp_err   <= re_n;
      rsp_last  <= rl_n;
    end
  end
endmodule

// File: rtl/lmem_cycle_ctrl.sv
module lmem_cycle_ctrl
  import lmc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int STAT_W  = 4,
  parameter int RCA_W   = 13,
  parameter int LEN_W   = 2,
  localparam int LANES   = DATA_W / 8,
  localparam int WADDR_W = DATA_W - STAT_W,
  localparam int AIN_W   = 2 * RCA_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [WADDR_W-1:0] req_addr,
  input  logic [STAT_W-1:0]  req_status,
  input  logic               req_write,
  input  logic [LANES-1:0]   req_be,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [LEN_W-1:0]   req_len,
  output logic               req_ack,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_err,
  output logic               rsp_last,
  output logic [DATA_W-1:0]  lad_out,
  input  logic [DATA_W-1:0]  lad_in,
  output logic               lad_oe,
  output logic               ale,
  output logic               ras_n,
  output logic [LANES-1:0]   cas_n,
  output logic [RCA_W-1:0]   rca,
  input  logic               colmode,
  input  logic               rdy,
  input  logic               fault,
  input  logic               page_n,
  input  logic               half_n,
  output logic               ddin,
  output logic               ddout_n
);
  logic [1:0]         rst_sync;
  logic               core_rst_n;
  lmc_state_t         st;
  logic [WADDR_W-1:0] cur_addr;
  logic [STAT_W-1:0]  cur_stat;
  logic               cur_wr, hsel, half_q;
  logic [LANES-1:0]   cur_be, cas_act;
  logic [DATA_W-1:0]  cur_wdata, lane_data;
  logic               dphase, col_phase;

  // reset asserts at once, leaves two clocks after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  lmc_seq #(.DATA_W(DATA_W), .STAT_W(STAT_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(core_rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_status(req_status),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .req_len(req_len), .req_ack(req_ack),
    .rdy(rdy), .fault(fault), .page_n(page_n), .half_n(half_n), .lad_in(lad_in),
    .st(st), .cur_addr(cur_addr), .cur_stat(cur_stat), .cur_wr(cur_wr),
    .cur_be(cur_be), .cur_wdata(cur_wdata), .hsel(hsel), .half_q(half_q),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_last(rsp_last)
  );

  lmc_lanes #(.DATA_W(DATA_W)) u_lanes (
    .wr(cur_wr), .be(cur_be), .half(half_q), .hsel(hsel), .wdata(cur_wdata),
    .cas_act(cas_act), .lane_data(lane_data)
  );

  lmc_rcmux #(.RCA_W(RCA_W)) u_rcmux (
    .addr(cur_addr[AIN_W-1:0]), .hsel(hsel), .colmode(colmode),
    .col_phase(col_phase), .rca(rca)
  );

  assign dphase    = (st == ST_COL);
  assign col_phase = (st == ST_COL) || (st == ST_PRE);
  assign ale       = (st == ST_IDLE) || (st == ST_ADDR);
  assign ras_n     = !((st == ST_ROW) || col_phase);
  assign cas_n     = dphase ? ~cas_act : '1;
  assign lad_oe    = (st == ST_ADDR) || (dphase && cur_wr);
  assign lad_out   = (st == ST_ADDR) ? {cur_addr, cur_stat} : lane_data;
  assign ddin      = dphase && !cur_wr;
  assign ddout_n   = !(dphase && cur_wr);
endmodule

// File: rtl/lmc_checker.sv
module lmc_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ale,
  input logic             ras_n,
  input logic [LANES-1:0] cas_n,
  input logic             lad_oe,
  input logic             ddin,
  input logic             ddout_n,
  input logic             rdy,
  input logic             fault,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic             rsp_last
);
  logic dph;
  assign dph = ddin || !ddout_n;

  assert_dir_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ddin && !ddout_n));

  assert_cas_under_ras_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != '1) |-> !ras_n);

  assert_strobe_after_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ($past(lad_oe) && !ras_n));

  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dph && !rdy && !fault) |=> ($stable(cas_n) && $stable(ddin) && $stable(ddout_n) && !ras_n));

  assert_retry_readdress_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dph && rdy && fault) |=> (ras_n && ale && lad_oe && !rsp_valid));

  assert_fault_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dph && !rdy && fault) |=> (rsp_valid && rsp_err && rsp_last && ras_n));

  assert_rsp_follows_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(dph));
endmodule

bind lmem_cycle_ctrl lmc_checker #(.LANES(LANES)) u_lmc_checker (
  .clk(clk), .rst_n(rst_n), .ale(ale), .ras_n(ras_n), .cas_n(cas_n),
  .lad_oe(lad_oe), .ddin(ddin), .ddout_n(ddout_n), .rdy(rdy), .fault(fault),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_last(rsp_last)
);

// File: tb/lmem_cycle_ctrl_bench.sv
module lmem_cycle_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk, rst_n;
  logic        req_valid, req_write, req_ack;
  logic [27:0] req_addr;
  logic [3:0]  req_status, req_be, cas_n;
  logic [31:0] req_wdata, rsp_data, lad_out, lad_in;
  logic [1:0]  req_len;
  logic        rsp_valid, rsp_err, rsp_last, lad_oe, ale, ras_n;
  logic [12:0] rca;
  logic        colmode, rdy, fault, page_n, half_n, ddin, ddout_n;

  lmem_cycle_ctrl u_lmem_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_status(req_status), .req_write(req_write), .req_be(req_be),
    .req_wdata(req_wdata), .req_len(req_len), .req_ack(req_ack),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_last(rsp_last),
    .lad_out(lad_out), .lad_in(lad_in), .lad_oe(lad_oe), .ale(ale), .ras_n(ras_n),
    .cas_n(cas_n), .rca(rca), .colmode(colmode), .rdy(rdy), .fault(fault),
    .page_n(page_n), .half_n(half_n), .ddin(ddin), .ddout_n(ddout_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference model state: 0 idle, 1 address, 2 row, 3 data, 4 precharge
  int          m_st = 0;
  logic [27:0] m_addr;
  logic [3:0]  m_stat, m_be;
  logic        m_wr, m_h, m_half, m_page, m_retried, m_waited;
  logic [31:0] m_wd;
  logic [1:0]  m_left;
  logic        e_rv = 0, e_err = 0, e_last = 0, e_chk = 0;
  logic [31:0] e_data;
  string       e_tag = "R11";

  // pending transaction and knobs
  bit          pending = 0;
  logic [27:0] t_addr;
  logic [3:0]  t_stat, t_be;
  logic        t_wr, t_page, t_half, t_cm;
  logic [31:0] t_wd;
  logic [1:0]  t_len;
  int          n_retry = 0, n_wait = 0, p_fault = 8;
  bit          force_err = 0;

  function automatic logic [31:0] mw(logic [27:0] a);
    return ({4'h0, a} * 32'h9E3779B1) ^ 32'h13572468;
  endfunction
  function automatic logic [12:0] exp_col(logic [27:0] a, logic h, logic cm);
    logic [12:0] b;
    b = {a[11:0], h};
    return cm ? (b >> 1) : b;
  endfunction
  function automatic logic [3:0] exp_cas(logic wr, logic [3:0] be, logic half, logic h);
    logic [3:0] act;
    if (!half) act = wr ? be : 4'hF;
    else begin
      act[3:2] = 2'b00;
      act[1:0] = wr ? (h ? be[3:2] : be[1:0]) : 2'b11;
    end
    return ~act;
  endfunction
  function automatic logic [31:0] exp_lane(logic [31:0] wd, logic half, logic h);
    logic [15:0] s;
    s = h ? wd[31:16] : wd[15:0];
    return half ? {s, s} : wd;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic [8:0] ctl;
    ctl = {ale, ras_n, cas_n, lad_oe, ddin, ddout_n};
    chk("R11 rsp_valid", rsp_valid, e_rv);
    if (e_rv) begin
      chk(e_err ? "R6" : "R11", {rsp_err, rsp_last}, {e_err, e_last});
      if (e_chk) chk(e_tag, rsp_data, e_data);
    end
    case (m_st)
      0: chk("R12 idle strobes", ctl, {1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1});
      1: begin
        chk(m_retried ? "R5" : "R1", ctl, {1'b1, 1'b1, 4'hF, 1'b1, 1'b0, 1'b1});
        chk(m_retried ? "R5" : "R1", lad_out, {m_addr, m_stat});
      end
      2: begin
        chk("R2", ctl, {1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 1'b1});
        chk("R2", rca, m_addr[24:12]);
      end
      3: begin
        chk(m_waited ? "R4" : "R3", rca, exp_col(m_addr, m_h, t_cm));
        chk(m_half ? "R8" : "R9", cas_n, exp_cas(m_wr, m_be, m_half, m_h));
        chk("R10", {ale, ras_n, lad_oe, ddin, ddout_n}, {1'b0, 1'b0, m_wr, !m_wr, !m_wr});
        if (m_wr) chk("R8", lad_out, exp_lane(m_wd, m_half, m_h));
      end
      default: begin
        chk("R7", ctl, {1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 1'b1});
        chk("R3", rca, exp_col(m_addr, m_h, t_cm));
      end
    endcase
  endtask

  task automatic step();
    @(negedge clk);
    check_outputs();
    // drive inputs for the coming edge
    if (m_st == 0) begin
      if (pending) begin
        req_valid = 1; req_addr = t_addr; req_status = t_stat; req_write = t_wr;
        req_be = t_be; req_wdata = t_wd; req_len = t_len; colmode = t_cm;
        pending = 0;
      end else req_valid = 0;
    end else begin
      req_valid = 1'($urandom % 2); req_addr = 28'($urandom); req_status = 4'($urandom);
      req_write = 1'($urandom); req_len = 2'($urandom);
    end
    if (m_st == 3) begin
      if (n_retry > 0) begin rdy = 1; fault = 1; n_retry--; end
      else if (n_wait > 0) begin rdy = 0; fault = 0; n_wait--; end
      else if (force_err) begin rdy = 0; fault = 1; force_err = 0; end
      else begin
        rdy = ($urandom % 100) < 70;
        fault = ($urandom % 100) < p_fault;
      end
      lad_in = m_half ? (m_h ? {16'h5A5A, mw(m_addr)[31:16]} : {16'hA5A5, mw(m_addr)[15:0]})
                      : mw(m_addr);
    end else begin
      rdy = 1'($urandom); fault = 1'($urandom); lad_in = $urandom;
    end
    if (m_st == 2) begin page_n = !t_page; half_n = !t_half; end
    else begin page_n = 1'($urandom); half_n = 1'($urandom); end
    #1;
    chk("R12 ack", req_ack, (m_st == 0) && req_valid);
    // advance the model
    e_rv = 0; e_err = 0; e_last = 0; e_chk = 0;
    case (m_st)
      0: if (req_valid) begin
        m_addr = req_addr; m_stat = req_status; m_wr = req_write; m_be = req_be;
        m_wd = req_wdata; m_left = req_len; m_h = 0; m_retried = 0; m_st = 1;
      end
      1: begin m_st = 2; m_retried = 0; end
      2: begin m_half = !half_n; m_page = !page_n; m_waited = 0; m_st = 3; end
      3: begin
        if (fault && rdy) begin m_st = 1; m_retried = 1; end
        else if (fault) begin
          e_rv = 1; e_err = 1; e_last = 1; m_h = 0; m_st = 0;
        end else if (!rdy) m_waited = 1;
        else begin
          m_waited = 0;
          if (m_half && !m_h) begin m_h = 1; m_st = 4; end
          else begin
            e_rv = 1; e_last = (m_left == 0); e_data = mw(m_addr);
            e_chk = !m_wr; e_tag = m_half ? "R8" : "R11"; m_h = 0;
            if (m_left == 0) m_st = 0;
            else begin
              m_left = m_left - 1; m_addr = m_addr + 1;
              m_st = m_page ? 4 : 1;
            end
          end
        end
      end
      default: m_st = 3;
    endcase
  endtask

  task automatic run_txn(logic [27:0] a, logic [3:0] s, logic wr, logic [3:0] be,
                         logic [31:0] wd, logic [1:0] len, logic pg, logic hf, logic cm);
    t_addr = a; t_stat = s; t_wr = wr; t_be = be; t_wd = wd; t_len = len;
    t_page = pg; t_half = hf; t_cm = cm; pending = 1;
    do step(); while (pending || m_st != 0);
    step();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog: actual no completion expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7150));
    rst_n = 0; req_valid = 0; req_addr = 0; req_status = 0; req_write = 0;
    req_be = 0; req_wdata = 0; req_len = 0; lad_in = 0; colmode = 0;
    rdy = 0; fault = 0; page_n = 1; half_n = 1; t_cm = 0;
    // reset state, R12
    repeat (3) begin
      @(negedge clk);
      chk("R12 reset", {ale, ras_n, cas_n, lad_oe, ddin, ddout_n, rsp_valid},
          {1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0});
    end
    rst_n = 1;
    repeat (4) step();
    // R1 R2 R11: single read, plain geometry
    run_txn(28'h0ABC123, 4'h5, 0, 4'hF, 32'h0, 2'd0, 0, 0, 0);
    // R9 R7: byte-masked write burst under one row
    run_txn(28'h0123450, 4'h3, 1, 4'b0101, 32'hCAFEF00D, 2'd1, 1, 0, 0);
    // R4: three wait states
    n_wait = 3;
    run_txn(28'h0F0F0F0, 4'h9, 0, 4'hF, 32'h0, 2'd0, 0, 0, 1);
    // R5: two retries inside a 16-bit read
    n_retry = 2;
    run_txn(28'h0777777, 4'h1, 0, 4'hF, 32'h0, 2'd0, 0, 1, 0);
    // R6: fault without ready aborts a four-word burst
    force_err = 1;
    run_txn(28'h0001FFE, 4'h2, 0, 4'hF, 32'h0, 2'd3, 1, 0, 0);
    // R8 R7: 16-bit read burst in page mode
    run_txn(28'h0246800, 4'h4, 0, 4'hF, 32'h0, 2'd2, 1, 1, 0);
    // R8 R3: 16-bit write, shifted column
    run_txn(28'h0135790, 4'h6, 1, 4'b1001, 32'h89ABCDEF, 2'd1, 0, 1, 1);
    // R7: non-page burst re-addresses each word
    run_txn(28'h0FFFFFE, 4'hA, 0, 4'hF, 32'h0, 2'd3, 0, 0, 1);
    // constrained random mix
    for (int k = 0; k < 300; k++) begin
      if ($urandom % 10 == 0) n_retry = 1;
      if ($urandom % 8 == 0) n_wait = 1 + int'($urandom % 3);
      run_txn(28'($urandom), 4'($urandom), 1'($urandom), 4'($urandom), $urandom,
              2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    repeat (3) step();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule